// File: doc/BRIEF.md
# Banked DMA Channel Register File

This block holds the software-visible control and status registers of a multi-channel DMA engine. Software reaches the registers through a flat 32-bit write/read bus with a byte offset. Each channel keeps its own control, poll, descriptor base, descriptor count, interrupt status and interrupt enable registers. All of these sit behind a single window, and a channel-select register picks which copy that window shows. A port-select register does the same for the per-port control registers.

The movement engine outside this block reads the per-channel configuration from dedicated outputs: on, transmit direction, weight, descriptor base, descriptor count, and the burst lengths of each port. It reports hardware events as one-cycle pulses, one per channel and cause. The block folds these pulses into sticky status bits and drives a single interrupt line. A channel reset and an engine-wide reset both run for a fixed number of cycles. Each clears itself, so software can poll the reset bit until it reads zero.

Top module: `dma_chan_regs`

## Requirements
- R1: The register at offset 0x08 is read-only and reads {5'b0, channel count[26:20], port count[19:16], 11'b0, revision[4:0]}. With the defaults (4 channels, 2 ports, revision 0x15) it reads 0x00420015, and writes to it have no effect.
- R2: The value written to the channel-select register (0x18) decides which channel's copy is accessed at 0x14, 0x1C, 0x20, 0x24, 0x28 and 0x2C. Writing one channel's copy leaves every other channel's copy unchanged.
- R3: Channel control (0x1C) holds the on bit in bit 0, the transmit-direction bit in bit 8 and the weight in bits 17:16. These fields drive `ch_on_o`, `ch_tx_o` and `ch_weight_o`, and all other bits read 0.
- R4: Writing 1 to bit 1 of channel control starts a reset of the selected channel. Bit 1 then reads 1 for exactly RST_CYC (4) cycles and afterwards 0. While the reset runs, that channel's on bit, status and enables are zero and its events are dropped. Other channels are not affected.
- R5: Interrupt status (0x28) bits 6:1 are set by the channel's event pulses, where cause k sets bit k+1. Writing 1 to a bit clears it, so writing 0x7E clears them all. An event in the same cycle as a clearing write leaves its bit set. Bits 0 and 31:7 read 0.
- R6: Interrupt enable (0x2C) stores bits 6:1, with bit 3 enabling the descriptor-complete cause. All other bits read 0.
- R7: `irq_o` is 1 exactly when some channel n has a status bit whose enable is also set, and bit n of the node-enable register (0xF4) is 1.
- R8: The poll register (0x14) keeps bit 31 (polling on) and bit 6 (divide-by-4 poll clock) per channel. All other bits read 0.
- R9: The port-select register (0x40) picks the copy accessed at port control (0x44). Port control holds receive burst in bits 3:2, transmit burst in bits 5:4, packet drop in bit 6 and the endianness swap in bits 11:8, with burst codes 1, 2 and 3 meaning 2, 4 and 8 words. The burst fields drive `port_rx_burst_o` and `port_tx_burst_o`.
- R10: Writing 1 to bit 0 of global control (0x10) starts an engine reset. Bit 0 reads 1 for RST_CYC cycles. Meanwhile every channel's on bit, status and enables are held at zero. Descriptor base and count are kept.
- R11: Descriptor base (0x20, 32 bits) and descriptor count (0x24, DLEN_W bits) are stored per channel and drive `ch_desc_base_o` and `ch_desc_cnt_o`.
- R12: After `rst_ni` every register other than the ID reads 0, and `irq_o` and all channel outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe for the register bus |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| evt_i | input | N_CH*6 | Event pulses; channel c cause k at index c*6+k |
| ch_on_o | output | N_CH | Channel on, one bit per channel |
| ch_tx_o | output | N_CH | Transmit direction per channel |
| ch_weight_o | output | 2*N_CH | Weight per channel |
| ch_desc_base_o | output | 32*N_CH | Descriptor base per channel |
| ch_desc_cnt_o | output | DLEN_W*N_CH | Descriptor count per channel |
| port_rx_burst_o | output | 2*N_PORT | Receive burst code per port |
| port_tx_burst_o | output | 2*N_PORT | Transmit burst code per port |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is an event pulse that lands in the same cycle as a write-one-to-clear of its own status bit. A close second is an event that lands inside the few cycles of a running channel reset. The bench handles both by driving the bus write and the event vector in the same half-cycle. It then counts cycles from the reset write, so that it can place a pulse in a known cycle of the reset window. Afterwards it reads the status back through the channel window.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam logic [7:0] OFS_ID      = 8'h08;
  localparam logic [7:0] OFS_GCTRL   = 8'h10;
  localparam logic [7:0] OFS_POLL    = 8'h14;
  localparam logic [7:0] OFS_CSEL    = 8'h18;
  localparam logic [7:0] OFS_CCTRL   = 8'h1C;
  localparam logic [7:0] OFS_DBASE   = 8'h20;
  localparam logic [7:0] OFS_DCNT    = 8'h24;
  localparam logic [7:0] OFS_ISTAT   = 8'h28;
  localparam logic [7:0] OFS_IEN     = 8'h2C;
  localparam logic [7:0] OFS_PSEL    = 8'h40;
  localparam logic [7:0] OFS_PCTRL   = 8'h44;
  localparam logic [7:0] OFS_NODE_EN = 8'hF4;

  localparam int N_CAUSE   = 6;
  localparam int CAUSE_LSB = 1;
  localparam int CC_ON     = 0;
  localparam int CC_RST    = 1;
  localparam int CC_TX     = 8;
  localparam int CC_WT_LSB = 16;
  localparam int PL_EN     = 31;
  localparam int PL_DIV4   = 6;

  typedef struct packed {
    logic [3:0] swap;
    logic       drop;
    logic [1:0] tx_burst;
    logic [1:0] rx_burst;
  } port_cfg_t;
endpackage

// File: rtl/dma_port_slot.sv
module dma_port_slot
  import dma_regs_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_i,
  input  port_cfg_t cfg_i,
  output port_cfg_t cfg_o,
  output logic [31:0] rd_o
);
  port_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else if (wr_i) cfg_q <= cfg_i;
  end

  assign cfg_o = cfg_q;
  assign rd_o  = {20'b0, cfg_q.swap, 1'b0, cfg_q.drop, cfg_q.tx_burst, cfg_q.rx_burst, 2'b0};

  assert_port_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(cfg_q));
endmodule

// File: rtl/dma_chan_slot.sv
module dma_chan_slot
  import dma_regs_pkg::*;
#(
  parameter int DLEN_W  = 8,
  parameter int RST_CYC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               glb_clr_i,
  input  logic               wr_ctrl_i,
  input  logic               wr_poll_i,
  input  logic               wr_base_i,
  input  logic               wr_cnt_i,
  input  logic               wr_stat_i,
  input  logic               wr_ien_i,
  input  logic [31:0]        wdata_i,
  input  logic [N_CAUSE-1:0] evt_i,
  output logic [31:0]        ctrl_rd_o,
  output logic [31:0]        poll_rd_o,
  output logic [31:0]        stat_rd_o,
  output logic [31:0]        ien_rd_o,
  output logic [31:0]        base_o,
  output logic [DLEN_W-1:0]  cnt_o,
  output logic               on_o,
  output logic               tx_o,
  output logic [1:0]         weight_o,
  output logic               irq_o
);
  localparam int RC_W = $clog2(RST_CYC + 1);

  logic [RC_W-1:0]    rst_cnt;
  logic               on_q, tx_q, pl_en_q, pl_div_q;
  logic [1:0]         wt_q;
  logic [N_CAUSE-1:0] stat_q, ien_q, clr_mask;
  logic [31:0]        base_q;
  logic [DLEN_W-1:0]  cnt_q;
  logic               busy, start, hold;

  assign busy     = (rst_cnt != '0);
  assign start    = wr_ctrl_i & wdata_i[CC_RST];
  assign hold     = start | busy | glb_clr_i;
  assign clr_mask = wr_stat_i ? wdata_i[CAUSE_LSB +: N_CAUSE] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_cnt  <= '0;
      on_q     <= 1'b0;
      tx_q     <= 1'b0;
      wt_q     <= '0;
      pl_en_q  <= 1'b0;
      pl_div_q <= 1'b0;
      stat_q   <= '0;
      ien_q    <= '0;
      base_q   <= '0;
      cnt_q    <= '0;
    end else begin
      if (start)     rst_cnt <= RC_W'(RST_CYC);
      else if (busy) rst_cnt <= rst_cnt - 1'b1;

      if (wr_ctrl_i) begin
        tx_q <= wdata_i[CC_TX];
        wt_q <= wdata_i[CC_WT_LSB +: 2];
      end

      if (hold)           on_q <= 1'b0;
      else if (wr_ctrl_i) on_q <= wdata_i[CC_ON];

      // events beat a clearing write in the same cycle
      if (hold) stat_q <= '0;
      else      stat_q <= (stat_q & ~clr_mask) | evt_i;

      if (hold)          ien_q <= '0;
      else if (wr_ien_i) ien_q <= wdata_i[CAUSE_LSB +: N_CAUSE];

      if (wr_poll_i) begin
        pl_en_q  <= wdata_i[PL_EN];
        pl_div_q <= wdata_i[PL_DIV4];
      end
      if (wr_base_i) base_q <= wdata_i;
      if (wr_cnt_i)  cnt_q  <= wdata_i[DLEN_W-1:0];
    end
  end

  assign ctrl_rd_o = {14'b0, wt_q, 7'b0, tx_q, 6'b0, busy, on_q};
  assign poll_rd_o = {pl_en_q, 24'b0, pl_div_q, 6'b0};
  assign stat_rd_o = {{(31-N_CAUSE){1'b0}}, stat_q, 1'b0};
  assign ien_rd_o  = {{(31-N_CAUSE){1'b0}}, ien_q, 1'b0};
  assign base_o    = base_q;
  assign cnt_o     = cnt_q;
  assign on_o      = on_q;
  assign tx_o      = tx_q;
  assign weight_o  = wt_q;
  assign irq_o     = |(stat_q & ien_q);

  assert_reset_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (!on_q && stat_q == '0 && ien_q == '0));

  assert_reset_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_cnt <= RC_W'(RST_CYC));

  assert_event_sticks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0 && !hold) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));

  assert_global_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glb_clr_i |=> (!on_q && stat_q == '0 && ien_q == '0));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter int         N_CH    = 4,
  parameter int         N_PORT  = 2,
  parameter int         DLEN_W  = 8,
  parameter int         RST_CYC = 4,
  parameter logic [4:0] HW_REV  = 5'h15
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [7:0]                addr_i,
  input  logic [31:0]               wdata_i,
  output logic [31:0]               rdata_o,
  input  logic [N_CH*N_CAUSE-1:0]   evt_i,
  output logic [N_CH-1:0]           ch_on_o,
  output logic [N_CH-1:0]           ch_tx_o,
  output logic [2*N_CH-1:0]         ch_weight_o,
  output logic [32*N_CH-1:0]        ch_desc_base_o,
  output logic [DLEN_W*N_CH-1:0]    ch_desc_cnt_o,
  output logic [2*N_PORT-1:0]       port_rx_burst_o,
  output logic [2*N_PORT-1:0]       port_tx_burst_o,
  output logic                      irq_o
);
  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1;
  localparam int PT_W = (N_PORT > 1) ? $clog2(N_PORT) : 1;
  localparam int RC_W = $clog2(RST_CYC + 1);

  logic [CH_W-1:0] ch_sel;
  logic [PT_W-1:0] pt_sel;
  logic [N_CH-1:0] node_en, ch_irq;
  logic [RC_W-1:0] g_cnt;
  logic            g_busy, g_start, glb_clr;
  logic [31:0]     id_word;
  port_cfg_t       pcfg_wr;

  logic [31:0] ctrl_rd [N_CH];
  logic [31:0] poll_rd [N_CH];
  logic [31:0] stat_rd [N_CH];
  logic [31:0] ien_rd  [N_CH];
  logic [31:0] base_rd [N_CH];
  logic [DLEN_W-1:0] cnt_rd [N_CH];
  logic [31:0] pctl_rd [N_PORT];

  assign g_busy  = (g_cnt != '0);
  assign g_start = we_i && addr_i == OFS_GCTRL && wdata_i[0];
  assign glb_clr = g_start | g_busy;
  assign id_word = {5'b0, 7'(N_CH), 4'(N_PORT), 11'b0, HW_REV};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch_sel  <= '0;
      pt_sel  <= '0;
      node_en <= '0;
      g_cnt   <= '0;
    end else begin
      if (we_i && addr_i == OFS_CSEL)    ch_sel  <= wdata_i[CH_W-1:0];
      if (we_i && addr_i == OFS_PSEL)    pt_sel  <= wdata_i[PT_W-1:0];
      if (we_i && addr_i == OFS_NODE_EN) node_en <= wdata_i[N_CH-1:0];
      if (g_start)     g_cnt <= RC_W'(RST_CYC);
      else if (g_busy) g_cnt <= g_cnt - 1'b1;
    end
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic hit;
    assign hit = we_i && (ch_sel == CH_W'(c));
    dma_chan_slot #(.DLEN_W(DLEN_W), .RST_CYC(RST_CYC)) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .glb_clr_i (glb_clr),
      .wr_ctrl_i (hit && addr_i == OFS_CCTRL),
      .wr_poll_i (hit && addr_i == OFS_POLL),
      .wr_base_i (hit && addr_i == OFS_DBASE),
      .wr_cnt_i  (hit && addr_i == OFS_DCNT),
      .wr_stat_i (hit && addr_i == OFS_ISTAT),
      .wr_ien_i  (hit && addr_i == OFS_IEN),
      .wdata_i   (wdata_i),
      .evt_i     (evt_i[c*N_CAUSE +: N_CAUSE]),
      .ctrl_rd_o (ctrl_rd[c]),
      .poll_rd_o (poll_rd[c]),
      .stat_rd_o (stat_rd[c]),
      .ien_rd_o  (ien_rd[c]),
      .base_o    (base_rd[c]),
      .cnt_o     (cnt_rd[c]),
      .on_o      (ch_on_o[c]),
      .tx_o      (ch_tx_o[c]),
      .weight_o  (ch_weight_o[2*c +: 2]),
      .irq_o     (ch_irq[c])
    );
    assign ch_desc_base_o[32*c +: 32]        = base_rd[c];
    assign ch_desc_cnt_o[DLEN_W*c +: DLEN_W] = cnt_rd[c];
  end

  assign pcfg_wr = '{swap: wdata_i[11:8], drop: wdata_i[6],
                     tx_burst: wdata_i[5:4], rx_burst: wdata_i[3:2]};

  for (genvar p = 0; p < N_PORT; p++) begin : g_pt
    port_cfg_t cfg;
    dma_port_slot u_port (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (we_i && addr_i == OFS_PCTRL && pt_sel == PT_W'(p)),
      .cfg_i  (pcfg_wr),
      .cfg_o  (cfg),
      .rd_o   (pctl_rd[p])
    );
    assign port_rx_burst_o[2*p +: 2] = cfg.rx_burst;
    assign port_tx_burst_o[2*p +: 2] = cfg.tx_burst;
  end

  assign irq_o = |(ch_irq & node_en);

  logic ch_ok, pt_ok;
  assign ch_ok = (32'(ch_sel) < N_CH);
  assign pt_ok = (32'(pt_sel) < N_PORT);

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_ID:      rdata_o = id_word;
      OFS_GCTRL:   rdata_o = {31'b0, g_busy};
      OFS_CSEL:    rdata_o = 32'(ch_sel);
      OFS_PSEL:    rdata_o = 32'(pt_sel);
      OFS_NODE_EN: rdata_o = 32'(node_en);
      OFS_POLL:    if (ch_ok) rdata_o = poll_rd[ch_sel];
      OFS_CCTRL:   if (ch_ok) rdata_o = ctrl_rd[ch_sel];
      OFS_DBASE:   if (ch_ok) rdata_o = base_rd[ch_sel];
      OFS_DCNT:    if (ch_ok) rdata_o = 32'(cnt_rd[ch_sel]);
      OFS_ISTAT:   if (ch_ok) rdata_o = stat_rd[ch_sel];
      OFS_IEN:     if (ch_ok) rdata_o = ien_rd[ch_sel];
      OFS_PCTRL:   if (pt_ok) rdata_o = pctl_rd[pt_sel];
      default:     rdata_o = '0;
    endcase
  end

  assert_irq_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (node_en != '0 && ch_irq != '0));

  assert_glb_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    g_cnt <= RC_W'(RST_CYC));

  assert_glb_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    g_busy |-> (ch_on_o == '0 && !irq_o));
endmodule

// File: tb/dma_chan_regs_bench.sv
module dma_chan_regs_bench;
  localparam int NC = 4, NP = 2, DW = 8, RC = 4;

  logic clk = 0, rst_ni = 0, we = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [NC*6-1:0] evt = '0;
  logic [NC-1:0] on_o, tx_o;
  logic [2*NC-1:0] wt_o;
  logic [32*NC-1:0] base_o;
  logic [DW*NC-1:0] cnt_o;
  logic [2*NP-1:0] rxb_o, txb_o;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dma_chan_regs u_dma_chan_regs (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .evt_i(evt), .ch_on_o(on_o), .ch_tx_o(tx_o),
    .ch_weight_o(wt_o), .ch_desc_base_o(base_o), .ch_desc_cnt_o(cnt_o),
    .port_rx_burst_o(rxb_o), .port_tx_burst_o(txb_o), .irq_o(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse(input int c, input logic [5:0] m);
    @(negedge clk); evt[c*6 +: 6] = m;
    @(negedge clk); evt = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R12 reset state
    foreach (v[i]) if (i < 12) begin
      logic [7:0] a;
      a = (i == 0) ? 8'h10 : (i == 1) ? 8'h14 : (i == 2) ? 8'h18 : (i == 3) ? 8'h1C :
          (i == 4) ? 8'h20 : (i == 5) ? 8'h24 : (i == 6) ? 8'h28 : (i == 7) ? 8'h2C :
          (i == 8) ? 8'h40 : (i == 9) ? 8'h44 : 8'hF4;
      rd(a, v); chk($sformatf("R12 reset read %h", a), v, 0);
    end
    chk("R12 outputs after reset", {on_o, tx_o, wt_o, 7'b0, irq}, 0);
    // R1 identity
    rd(8'h08, v); chk("R1 id", v, 32'h0042_0015);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, v); chk("R1 id write ignored", v, 32'h0042_0015);

    // R2 R3 R8 R11 per-channel sweep
    for (int c = 0; c < NC; c++) begin
      wr(8'h18, c);
      wr(8'h1C, 32'hFFFC_FEFC | (c & 1) | ((c >> 1) << 8) | (c << 16) & 32'h0003_0000 | 32'h0);
      wr(8'h1C, (c & 1) | (((c >> 1) & 1) << 8) | (c << 16) | 32'h00C0_0000);
      wr(8'h20, 32'h1000_0000 + c * 32'h111);
      wr(8'h24, c * 7 + 3);
      wr(8'h14, ((c & 1) ? 32'h8000_0000 : 0) | ((c & 2) ? 32'h40 : 0) | 32'h1234);
    end
    for (int c = 0; c < NC; c++) begin
      wr(8'h18, c);
      rd(8'h1C, v); chk($sformatf("R3 ctrl ch%0d", c), v, (c & 1) | (((c >> 1) & 1) << 8) | (c << 16));
      chk($sformatf("R3 outputs ch%0d", c), {on_o[c], tx_o[c], wt_o[2*c +: 2]},
          {c[0], c[1], c[1:0]});
      rd(8'h20, v); chk($sformatf("R2 R11 base ch%0d", c), v, 32'h1000_0000 + c * 32'h111);
      chk($sformatf("R11 base out ch%0d", c), base_o[32*c +: 32], 32'h1000_0000 + c * 32'h111);
      rd(8'h24, v); chk($sformatf("R11 count ch%0d", c), v, c * 7 + 3);
      chk($sformatf("R11 count out ch%0d", c), 32'(cnt_o[DW*c +: DW]), c * 7 + 3);
      rd(8'h14, v); chk($sformatf("R8 poll ch%0d", c), v,
          ((c & 1) ? 32'h8000_0000 : 0) | ((c & 2) ? 32'h40 : 0));
    end
    rd(8'h18, v); chk("R2 select readback", v, 3);

    // R4 channel reset on ch1, with an event inside the window
    wr(8'h18, 1);
    pulse(1, 6'h3F);
    rd(8'h28, v); chk("R5 all causes set ch1", v, 32'h7E);
    wr(8'h2C, 32'h7E);
    wr(8'h1C, 32'h0000_0103);
    n = 0;
    for (int i = 0; i < 10; i++) begin
      rd(8'h1C, v);
      if (v[1]) begin
        n++;
        chk("R4 on low during reset", on_o[1], 0);
      end
      evt[6 +: 6] = (i == 1) ? 6'h3F : 6'h0;
      @(negedge clk);
    end
    evt = '0;
    chk("R4 reset window length", n, RC);
    rd(8'h28, v); chk("R4 status cleared", v, 0);
    rd(8'h2C, v); chk("R4 enable cleared", v, 0);
    rd(8'h1C, v); chk("R4 ctrl after reset", v, 32'h100);
    chk("R4 other channel kept on", on_o[3], 1);

    // R5 write-one-to-clear and event priority on ch2
    wr(8'h18, 2);
    pulse(2, 6'h3F);
    rd(8'h28, v); chk("R5 set", v, 32'h7E);
    wr(8'h28, 32'h08);
    rd(8'h28, v); chk("R5 single clear", v, 32'h76);
    wr(8'h28, 32'h7E);
    rd(8'h28, v); chk("R5 ack all", v, 0);
    pulse(2, 6'h3F);
    @(negedge clk); we = 1; addr = 8'h28; wdata = 32'hFFFF_FFFF; evt[12 +: 6] = 6'h04;
    @(negedge clk); we = 0; evt = '0;
    rd(8'h28, v); chk("R5 event beats clear", v, 32'h08);
    wr(8'h28, 32'h7E);

    // R6 R7 interrupt sweep
    for (int c = 0; c < NC; c++) begin
      wr(8'h18, c);
      wr(8'h2C, 32'hFFFF_FFFF);
      rd(8'h2C, v); chk($sformatf("R6 enable mask ch%0d", c), v, 32'h7E);
      for (int k = 0; k < 6; k++) begin
        wr(8'h28, 32'h7E);
        wr(8'h2C, 32'h1 << (k + 1));
        wr(8'hF4, 32'h1 << c);
        chk("R7 idle", irq, 0);
        pulse((c + 1) % NC, 6'h1 << k);
        chk($sformatf("R7 other channel ch%0d k%0d", c, k), irq, 0);
        pulse(c, 6'h1 << k);
        chk($sformatf("R7 raise ch%0d k%0d", c, k), irq, 1);
        wr(8'hF4, 0);
        chk($sformatf("R7 node gate ch%0d k%0d", c, k), irq, 0);
        wr(8'hF4, 32'h1 << c);
        wr(8'h2C, 0);
        chk($sformatf("R6 enable gate ch%0d k%0d", c, k), irq, 0);
        wr(8'h28, 32'h7E);
        wr(8'h18, (c + 1) % NC); wr(8'h28, 32'h7E); wr(8'h18, c);
      end
    end

    // R9 ports
    wr(8'h40, 0); wr(8'h44, 32'hFFFF_FFFF);
    wr(8'h40, 1); wr(8'h44, 32'h0000_0A18);
    wr(8'h40, 0); rd(8'h44, v); chk("R9 port0", v, 32'hF7C);
    wr(8'h40, 1); rd(8'h44, v); chk("R9 port1", v, 32'hA18);
    chk("R9 rx bursts", rxb_o, 4'b10_11);
    chk("R9 tx bursts", txb_o, 4'b01_11);

    // R10 global reset
    wr(8'h18, 0); wr(8'h1C, 1); wr(8'h2C, 32'h7E); pulse(0, 6'h3F);
    wr(8'h18, 3); wr(8'h1C, 1); wr(8'hF4, 32'hF);
    chk("R10 precondition irq", irq, 1);
    wr(8'h10, 1);
    n = 0;
    for (int i = 0; i < 10; i++) begin
      rd(8'h10, v);
      if (v[0]) begin
        n++;
        chk("R10 channels off during reset", on_o, 0);
      end
      @(negedge clk);
    end
    chk("R10 window length", n, RC);
    chk("R10 irq low", irq, 0);
    wr(8'h18, 0);
    rd(8'h28, v); chk("R10 status cleared", v, 0);
    rd(8'h2C, v); chk("R10 enable cleared", v, 0);
    rd(8'h20, v); chk("R10 base kept", v, 32'h1000_0000);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule